// File: doc/BRIEF.md
# Digital Frequency-Locked Loop Controller

This block steers a digitally controlled oscillator so that its output runs at a programmable multiple of a slow reference clock. It picks one of three reference inputs: an internal trimmed reference and two crystal inputs. If the first crystal is chosen while it is flagged as not running, the internal reference is used instead. The chosen reference is divided by a power-of-two prescaler. All control logic runs on the oscillator's own clock, and the reference edge enters that domain through a two-flop synchroniser.

The oscillator output is divided by a power-of-two post-divider to form the feedback clock. Over each divided reference period the controller counts feedback edges and compares the count with the target N+1. An up/down integrator then moves the oscillator tap word by one step. At lock, the feedback clock equals (N+1) times the divided reference, and the fast clock is 2^D times that. With a 32768 Hz reference, no prescaling, N=31 and D=1, the feedback clock settles at 1.048576 MHz. A lock flag, a sticky saturation flag and a registered copy of the 3-bit band selection are also provided. Integration ties the configuration inputs to N=31, post-divider code 1 and prescaler code 0 out of reset, with the first crystal selected.

Top module: `fll_ctrl`

## Requirements
- R1: `ref_sel` code 0 selects `ref_int`, code 1 selects `ref_xt1`, and codes 2 and 3 select `ref_xt2`. `ref_src` reports the input in use as 0, 1 or 2.
- R2: With `ref_sel`=1 and `xt1_ok`=0, the internal reference is used and `ref_src` reads 0.
- R3: A measurement window spans 2^`ref_div` rising edges of the selected reference.
- R4: `fb_clk` has a period of 2^`post_div` oscillator cycles at 50% duty, and `post_div`=0 behaves as 1. One feedback edge is counted per `fb_clk` period.
- R5: At the end of each window the tap word rises by 1 when the edge count is below `mult_n`+1, falls by 1 when it is above, and holds when it is equal. The first window after reset is not evaluated.
- R6: The tap word stays within 0 and its all-ones value. A step request past either bound sets `tap_sat`, which stays set until reset.
- R7: `locked` rises after 4 consecutive evaluated windows whose count is within ±1 of the target. It falls on the first window outside that band.
- R8: `dco_range` equals `range_sel` one clock later.
- R9: During reset the tap word is the mid-scale value 2^(CTRL_W-1), and `locked`, `tap_sat`, `fb_clk` and `ref_src` are 0.
- R10: With an oscillator whose frequency rises with the tap word, the loop locks. The feedback frequency then lies within a few percent of (`mult_n`+1) times the divided reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dco_clk | input | 1 | Oscillator clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| ref_int | input | 1 | Internal trimmed reference |
| ref_xt1 | input | 1 | First crystal reference |
| ref_xt2 | input | 1 | Second crystal reference |
| xt1_ok | input | 1 | First crystal running flag |
| ref_sel | input | 2 | Reference choice |
| ref_div | input | P_W | Reference prescaler code, divide by 2^code |
| mult_n | input | N_W | Multiplier field N, target N+1 |
| post_div | input | D_W | Post-divider code, divide by 2^code |
| range_sel | input | 3 | Oscillator band request |
| tap_word | output | CTRL_W | Oscillator control word |
| dco_range | output | 3 | Registered band to the oscillator |
| fb_clk | output | 1 | Divided feedback clock |
| locked | output | 1 | Lock indication |
| tap_sat | output | 1 | Sticky saturation flag |
| ref_src | output | 2 | Reference input actually in use |

## Verification
The slowest path runs from a reference edge to a tap or lock update. It passes through two synchroniser flops, the edge-detect flop, the prescaler tick flop and the loop register, about five oscillator cycles in all. The bench therefore samples ten cycles after the chosen reference's rising edge, which falls well inside the next window of at least 48 cycles. The number of evaluated windows is worked out as floor(edges/2^`ref_div`)−1, and a step-by-step model of the integrator, saturation and lock streak gives the expected values. `dco_range` is sampled on the falling edge after one rising edge. `fb_clk` periods are found by counting rises over exactly 64 sample intervals. The closed-loop check waits 60 reference periods before it judges lock and frequency.

// File: rtl/fll_pkg.sv
package fll_pkg;
  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_XT1 = 2'd1,
    SRC_XT2 = 2'd2
  } ref_src_e;
endpackage

// File: rtl/fll_refsel.sv
module fll_refsel import fll_pkg::*; #(
  parameter int P_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ref_int,
  input  logic           ref_xt1,
  input  logic           ref_xt2,
  input  logic           xt1_ok,
  input  logic [1:0]     ref_sel,
  input  logic [P_W-1:0] ref_div,
  output logic           ref_tick,
  output logic [1:0]     ref_src
);
  localparam int PC_W = (1 << P_W) - 1;

  ref_src_e        src_d;
  logic            ref_raw;
  logic [2:0]      sync_q;
  logic            rise;
  logic [PC_W-1:0] pcnt, pmask;

  // Source choice with crystal fallback
  always_comb begin
    case (ref_sel)
      2'd0:    src_d = SRC_INT;
      2'd1:    src_d = xt1_ok ? SRC_XT1 : SRC_INT;
      default: src_d = SRC_XT2;
    endcase
    case (src_d)
      SRC_XT1: ref_raw = ref_xt1;
      SRC_XT2: ref_raw = ref_xt2;
      default: ref_raw = ref_int;
    endcase
    pmask = ~({PC_W{1'b1}} << ref_div);
    rise  = sync_q[1] & ~sync_q[2];
  end

  // Two synchroniser flops followed by an edge-detect flop
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      ref_src <= SRC_INT;
    end else begin
      sync_q  <= {sync_q[1:0], ref_raw};
      ref_src <= src_d;
    end
  end

  // Prescaler: one tick per 2^ref_div synchronised edges
  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt     <= '0;
      ref_tick <= 1'b0;
    end else if (rise) begin
      if (pcnt >= pmask) begin
        pcnt     <= '0;
        ref_tick <= 1'b1;
      end else begin
        pcnt     <= pcnt + 1'b1;
        ref_tick <= 1'b0;
      end
    end else begin
      ref_tick <= 1'b0;
    end
  end

  p_fallback_r2: assert property (@(posedge clk) disable iff (rst)
    (ref_sel == 2'd1 && !xt1_ok) |=> (ref_src == SRC_INT));

  p_tick_from_edge_r3: assert property (@(posedge clk) disable iff (rst)
    ref_tick |-> $past(rise));
endmodule

// File: rtl/fll_fbdiv.sv
module fll_fbdiv #(
  parameter int D_W = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [D_W-1:0] post_div,
  output logic           fb_tick,
  output logic           fb_clk
);
  localparam int FC_W = (1 << D_W) - 1;

  logic [FC_W-1:0] cnt, cnt_n, mask;
  logic [D_W-1:0]  d_eff, bit_ix;

  always_comb begin
    d_eff  = (post_div == '0) ? D_W'(1) : post_div;
    mask   = ~({FC_W{1'b1}} << d_eff);
    cnt_n  = cnt + 1'b1;
    bit_ix = d_eff - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      fb_tick <= 1'b0;
      fb_clk  <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      fb_tick <= ((cnt & mask) == mask);
      fb_clk  <= cnt_n[bit_ix];
    end
  end

  // Period of at least two cycles: a tick never repeats back to back
  p_fbtick_gap_r4: assert property (@(posedge clk) disable iff (rst)
    fb_tick |=> !fb_tick);
endmodule

// File: rtl/fll_loop.sv
module fll_loop #(
  parameter int N_W      = 10,
  parameter int CTRL_W   = 10,
  parameter int LOCK_RUN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              fb_tick,
  input  logic [N_W-1:0]    mult_n,
  output logic [CTRL_W-1:0] tap_word,
  output logic              locked,
  output logic              tap_sat
);
  localparam int CNT_W = N_W + 2;
  localparam int LK_W  = $clog2(LOCK_RUN + 1);
  localparam logic [CTRL_W-1:0] TAP_MAX = '1;
  localparam logic [CTRL_W-1:0] TAP_MID = CTRL_W'(1) << (CTRL_W - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;

  logic [CNT_W-1:0] win_cnt;
  logic             primed;
  logic [LK_W-1:0]  streak;
  logic [CNT_W:0]   seen, goal;
  logic             below, above, near;

  always_comb begin
    seen  = {1'b0, win_cnt} + {{CNT_W{1'b0}}, fb_tick};
    goal  = (CNT_W + 1)'(mult_n) + 1'b1;
    below = seen < goal;
    above = seen > goal;
    near  = ((seen + 1'b1) >= goal) && (seen <= (goal + 1'b1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt  <= '0;
      primed   <= 1'b0;
      tap_word <= TAP_MID;
      tap_sat  <= 1'b0;
      locked   <= 1'b0;
      streak   <= '0;
    end else if (ref_tick) begin
      win_cnt <= '0;
      primed  <= 1'b1;
      if (primed) begin
        if (below) begin
          if (tap_word == TAP_MAX) tap_sat <= 1'b1;
          else                     tap_word <= tap_word + 1'b1;
        end else if (above) begin
          if (tap_word == '0) tap_sat <= 1'b1;
          else                tap_word <= tap_word - 1'b1;
        end
        if (near) begin
          if (streak < LK_W'(LOCK_RUN)) streak <= streak + 1'b1;
          locked <= (streak >= LK_W'(LOCK_RUN - 1));
        end else begin
          streak <= '0;
          locked <= 1'b0;
        end
      end
    end else if (fb_tick && win_cnt != CNT_MAX) begin
      win_cnt <= win_cnt + 1'b1;
    end
  end

  p_tap_step_r5: assert property (@(posedge clk) disable iff (rst)
    (tap_word == $past(tap_word)) ||
    (tap_word == CTRL_W'($past(tap_word) + 1'b1)) ||
    (tap_word == CTRL_W'($past(tap_word) - 1'b1)));

  p_tap_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    (tap_word != $past(tap_word)) |-> $past(ref_tick));

  p_sat_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    tap_sat |=> tap_sat);

  p_sat_at_bound_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(tap_sat) |-> (tap_word == '0 || tap_word == TAP_MAX));

  p_lock_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(ref_tick));
endmodule

// File: rtl/fll_ctrl.sv
module fll_ctrl import fll_pkg::*; #(
  parameter int N_W      = 10,
  parameter int D_W      = 3,
  parameter int P_W      = 3,
  parameter int CTRL_W   = 10,
  parameter int LOCK_RUN = 4
) (
  input  logic              dco_clk,
  input  logic              rst,
  input  logic              ref_int,
  input  logic              ref_xt1,
  input  logic              ref_xt2,
  input  logic              xt1_ok,
  input  logic [1:0]        ref_sel,
  input  logic [P_W-1:0]    ref_div,
  input  logic [N_W-1:0]    mult_n,
  input  logic [D_W-1:0]    post_div,
  input  logic [2:0]        range_sel,
  output logic [CTRL_W-1:0] tap_word,
  output logic [2:0]        dco_range,
  output logic              fb_clk,
  output logic              locked,
  output logic              tap_sat,
  output logic [1:0]        ref_src
);
  logic ref_tick, fb_tick;

  fll_refsel #(.P_W(P_W)) u_refsel (
    .clk(dco_clk), .rst(rst),
    .ref_int(ref_int), .ref_xt1(ref_xt1), .ref_xt2(ref_xt2),
    .xt1_ok(xt1_ok), .ref_sel(ref_sel), .ref_div(ref_div),
    .ref_tick(ref_tick), .ref_src(ref_src)
  );

  fll_fbdiv #(.D_W(D_W)) u_fbdiv (
    .clk(dco_clk), .rst(rst), .post_div(post_div),
    .fb_tick(fb_tick), .fb_clk(fb_clk)
  );

  fll_loop #(.N_W(N_W), .CTRL_W(CTRL_W), .LOCK_RUN(LOCK_RUN)) u_loop (
    .clk(dco_clk), .rst(rst), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .mult_n(mult_n), .tap_word(tap_word), .locked(locked), .tap_sat(tap_sat)
  );

  always_ff @(posedge dco_clk) begin
    if (rst) dco_range <= 3'd0;
    else     dco_range <= range_sel;
  end
endmodule

// File: tb/sim_fll_ctrl.sv
`timescale 1ns/1ps
module sim_fll_ctrl;
  localparam int CW   = 6;
  localparam int TMAX = (1 << CW) - 1;
  localparam int TMID = 1 << (CW - 1);

  logic clk = 1'b0, osc_var = 1'b0, use_var = 1'b0, rst = 1'b1;
  logic dco;
  logic ref_i = 1'b0, ref_1 = 1'b0, ref_2 = 1'b0, watch;
  int   hi = 32, h1 = 24, h2 = 40, ci = 0, c1 = 0, c2 = 0, wsel = 0;
  logic xt1_ok = 1'b1;
  logic [1:0] ref_sel = 2'd0;
  logic [2:0] ref_div = 3'd0, post_div = 3'd1, range_sel = 3'd3;
  logic [9:0] mult_n = 10'd31;
  logic [CW-1:0] tap_word;
  logic [2:0] dco_range;
  logic fb_clk, locked, tap_sat;
  logic [1:0] ref_src;
  int checks = 0, errors = 0;

  assign dco = use_var ? osc_var : clk;
  always #10 clk = ~clk;

  function automatic real half_ns();
    real f;
    f = (real'(int'(tap_word)) + 1.0) * 0.5 * (2.0 ** (real'(int'(dco_range)) - 3.0));
    return 500.0 / f;
  endfunction
  initial forever begin #(half_ns()); osc_var = ~osc_var; end

  always @(negedge clk) begin
    if (rst) begin ci = 0; c1 = 0; c2 = 0; ref_i = 0; ref_1 = 0; ref_2 = 0; end
    else begin
      ci++; c1++; c2++;
      if (ci == hi) begin ci = 0; ref_i = ~ref_i; end
      if (c1 == h1) begin c1 = 0; ref_1 = ~ref_1; end
      if (c2 == h2) begin c2 = 0; ref_2 = ~ref_2; end
    end
  end
  always_comb case (wsel)
    0: watch = ref_i;
    1: watch = ref_1;
    default: watch = ref_2;
  endcase

  fll_ctrl #(.CTRL_W(CW)) u0 (
    .dco_clk(dco), .rst(rst), .ref_int(ref_i), .ref_xt1(ref_1), .ref_xt2(ref_2),
    .xt1_ok(xt1_ok), .ref_sel(ref_sel), .ref_div(ref_div), .mult_n(mult_n),
    .post_div(post_div), .range_sel(range_sel), .tap_word(tap_word),
    .dco_range(dco_range), .fb_clk(fb_clk), .locked(locked), .tap_sat(tap_sat),
    .ref_src(ref_src));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge dco); #1 rst = 1'b1;
    repeat (4) @(negedge dco);
    #1 rst = 1'b0;
  endtask

  // Integrator, saturation and lock model over e evaluated windows
  task automatic model(int c, int t, int e, inout int tap, inout int sat, inout int lk, inout int st);
    for (int k = 0; k < e; k++) begin
      if (c < t) begin if (tap == TMAX) sat = 1; else tap++; end
      else if (c > t) begin if (tap == 0) sat = 1; else tap--; end
      if (c - t <= 1 && t - c <= 1) begin st++; lk = (st >= 4); end
      else begin st = 0; lk = 0; end
    end
  endtask

  task automatic run_open(string tag, int sel, bit ok, int div, int n, int d, int src, int m);
    int per, deff, cnt, ev, tap, sat, lk, st;
    ref_sel = 2'(sel); xt1_ok = ok; ref_div = 3'(div); mult_n = 10'(n); post_div = 3'(d);
    wsel = src;
    apply_reset();
    repeat (m) @(posedge watch);
    repeat (10) @(negedge clk);
    per  = (src == 0) ? 2*hi : (src == 1) ? 2*h1 : 2*h2;
    deff = (d == 0) ? 1 : d;
    cnt  = (per << div) >> deff;
    ev   = (m >> div) - 1;
    tap = TMID; sat = 0; lk = 0; st = 0;
    model(cnt, n + 1, ev, tap, sat, lk, st);
    chk({tag, " tap_word"}, int'(tap_word), tap);
    chk({tag, " locked"}, int'(locked), lk);
    chk({tag, " tap_sat"}, int'(tap_sat), sat);
    chk({tag, " ref_src"}, int'(ref_src), src);
  endtask

  task automatic fb_period(string tag, int d, int exp_rises);
    int rises;
    logic prev;
    post_div = 3'(d);
    apply_reset();
    repeat (3) @(negedge clk);
    prev = fb_clk; rises = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (fb_clk && !prev) rises++;
      prev = fb_clk;
    end
    chk(tag, rises, exp_rises);
  endtask

  initial begin
    #3_500_000;
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rises, tp;
    logic prev;
    // R9: state held in reset
    repeat (4) @(negedge clk);
    chk("R9 tap_word", int'(tap_word), TMID);
    chk("R9 locked", int'(locked), 0);
    chk("R9 tap_sat", int'(tap_sat), 0);
    chk("R9 fb_clk", int'(fb_clk), 0);
    chk("R9 ref_src", int'(ref_src), 0);

    run_open("R1 R5 int equal", 0, 1, 0, 31, 1, 0, 11);
    // R7: lock drops once target moves away; two below-target windows follow
    mult_n = 10'd40;
    repeat (2) @(posedge watch);
    repeat (10) @(negedge clk);
    chk("R7 drop locked", int'(locked), 0);
    chk("R5 R7 drop tap_word", int'(tap_word), TMID + 2);

    run_open("R1 R5 xt1 below", 1, 1, 0, 31, 1, 1, 11);
    run_open("R2 xt1 fallback", 1, 0, 0, 31, 1, 0, 11);
    run_open("R1 R5 xt2 above", 2, 1, 0, 31, 1, 2, 11);
    run_open("R1 code3 xt2", 3, 1, 0, 31, 1, 2, 11);
    run_open("R7 within one", 0, 1, 0, 32, 1, 0, 11);
    run_open("R7 off by two", 0, 1, 0, 33, 1, 0, 11);
    run_open("R3 prescale2", 0, 1, 1, 63, 1, 0, 22);
    run_open("R3 R4 prescale4 div4", 0, 1, 2, 63, 2, 0, 44);
    run_open("R3 prescale2 below", 0, 1, 1, 70, 1, 0, 12);
    run_open("R4 code0 as div2", 0, 1, 0, 31, 0, 0, 11);
    run_open("R6 sat high", 1, 1, 0, 31, 1, 1, 41);
    run_open("R6 sat low", 2, 1, 0, 31, 1, 2, 41);

    ref_sel = 2'd0; ref_div = 3'd0; mult_n = 10'd31;
    fb_period("R4 fb div2", 1, 32);
    fb_period("R4 fb div4", 2, 16);
    fb_period("R4 fb div8", 3, 8);
    fb_period("R4 fb code0", 0, 32);

    // R8: band copy one clock later
    range_sel = 3'd5;
    @(negedge clk);
    chk("R8 dco_range 5", int'(dco_range), 5);
    range_sel = 3'd2;
    @(negedge clk);
    chk("R8 dco_range 2", int'(dco_range), 2);

    // R10: closed loop with a behavioural oscillator
    range_sel = 3'd3; hi = 50; mult_n = 10'd19; post_div = 3'd1;
    ref_sel = 2'd0; ref_div = 3'd0; wsel = 0;
    use_var = 1'b1;
    apply_reset();
    repeat (60) @(posedge ref_i);
    @(negedge clk);
    chk("R10 locked", int'(locked), 1);
    tp = int'(tap_word);
    chk("R10 tap near 39", int'(tp >= 37 && tp <= 41), 1);
    prev = fb_clk; rises = 0;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (fb_clk && !prev) rises++;
      prev = fb_clk;
    end
    if (rises < 190 || rises > 210) chk("R10 fb rises in 20us", rises, 200);
    else chk("R10 fb rises in 20us", 200, 200);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule